// File: doc/BRIEF.md
# Burst Cut-Short Tracker for Low-Power DDR Commands

This block watches the column command stream of a low-power DDR memory controller, one command per rising clock edge. It follows the burst that is in flight and judges two ways of ending it early. A second column command in the same direction may cut into the burst. A burst-stop command, recognised from the raw chip-select and command/address bits, may also end it. When a burst ends, the block reports the effective burst length, and for a burst-stop it also marks the cycle at which the data for the cut burst stops. Analog skews are modelled as whole cycles.

Illegal commands produce a one-cycle violation pulse with an error code, and the tracker ignores them. Its state then moves on as if a NOP had been issued. Write latency, read latency and the minimum column-to-column spacing are runtime inputs. The programmed burst length BL (4, 8 or 16), an extra read-side skew in cycles and a turnaround gap are parameters. In the text below, k is the number of clock cycles from the burst's READ/WRITE edge to the current edge.

Top module: `burst_trunc_tracker`

## Requirements
- R1: A burst-stop is decoded only when cs_n is low and ca[3:0] equals 4'b0011 (ca[0]=1, ca[1]=1, ca[2]=0, ca[3]=0). With cs_n high, or with any other ca pattern and no read/write strobe, the edge acts as a NOP.
- R2: While a burst is active (k < BL/2), a command in the same direction at an even k with k >= tccd is legal. It reports an effective length of 2k on ebl (ebl_valid high) and starts a new burst.
- R3: A same-direction command during an active burst at an odd k gives viol with code 2 and is ignored.
- R4: A same-direction command during an active burst at an even k below tccd gives viol with code 3 and is ignored.
- R5: A command in the other direction during an active burst gives viol with code 1 and is ignored.
- R6: A burst-stop while a burst is active (1 <= k <= BL/2-1) reports ebl = 2k and ends the burst. It acts only on the latest burst. A burst-stop with no active burst gives viol with code 4.
- R7: A burst that is not cut short reports ebl = BL at the edge BL/2 cycles after its command. burst_active is high from the command edge until k reaches BL/2.
- R8: After a legal burst-stop edge, data_stop pulses high for one cycle after the edge that lies wl cycles later for a write burst, or rl+RD_SKEW cycles later for a read burst.
- R9: After a burst has ended, a command in the other direction needs k >= E/2 + TURN_GAP, where E is the burst's effective length (the cut length if it was cut short). An earlier one gives viol with code 5 and is ignored.
- R10: Any READ, WRITE or burst-stop issued while wl, rl or tccd is zero gives viol with code 6 and is ignored. This check outranks all others.
- R11: Reset clears all tracked state. After reset every output is low and no burst is active.
- R12: viol, viol_code, ebl_valid and ebl are registered and appear in the cycle after the command edge. viol_code is 0 whenever viol is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ca | input | 4 | Raw command/address bits 3..0 |
| cmd_rd | input | 1 | Decoded READ (qualified by cs_n low) |
| cmd_wr | input | 1 | Decoded WRITE (qualified by cs_n low) |
| wl | input | LAT_W | Write latency in cycles |
| rl | input | LAT_W | Read latency in cycles |
| tccd | input | LAT_W | Minimum column-to-column spacing in cycles |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Error code (0 none) |
| ebl_valid | output | 1 | Effective burst length report strobe |
| ebl | output | EW | Effective burst length in beats |
| burst_active | output | 1 | A burst is in progress |
| data_stop | output | 1 | Data of a cut-short burst ends in this cycle |

## Verification
On every cycle, the assertions check these properties:
- viol_code is consistent with viol.
- Every reported length is nonzero and at most BL.
- A legal same-direction interrupt reports a length that is a multiple of four.
- A legal burst-stop leaves no burst active.
- A zero latency or spacing input turns the next command into a code-6 pulse.

Only the bench scenarios can show the exact cycle timing: at which edge a full-length burst is reported, when data_stop fires for each direction, how a turnaround check uses a shortened length, and that a rejected command leaves the burst timing unchanged.

// File: rtl/btt_pkg.sv
package btt_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_BST = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_DIR    = 3'd1,
    ERR_ODD    = 3'd2,
    ERR_CCD    = 3'd3,
    ERR_BSTWIN = 3'd4,
    ERR_TURN   = 3'd5,
    ERR_CFG    = 3'd6
  } err_e;

  // burst-stop: select low, ca[1:0] high, ca[3:2] low
  function automatic logic is_stop_code(input logic sel_n, input logic [3:0] cab);
    return !sel_n && (cab == 4'b0011);
  endfunction

  // effective length in beats for a burst cut after a given cycle count
  function automatic int cut_len(input int cycles);
    return 2 * cycles;
  endfunction

endpackage

// File: rtl/btt_cmd_decode.sv
module btt_cmd_decode
  import btt_pkg::*;
(
  input  logic       cs_n,
  input  logic [3:0] ca,
  input  logic       cmd_rd,
  input  logic       cmd_wr,
  output cmd_e       cmd
);
  always_comb begin
    if (cs_n)                  cmd = CMD_NOP;
    else if (is_stop_code(cs_n, ca)) cmd = CMD_BST;
    else if (cmd_wr)           cmd = CMD_WR;
    else if (cmd_rd)           cmd = CMD_RD;
    else                       cmd = CMD_NOP;
  end
endmodule

// File: rtl/btt_burst_state.sv
module btt_burst_state
  import btt_pkg::*;
#(
  parameter int BL       = 8,
  parameter int LAT_W    = 4,
  parameter int TURN_GAP = 1,
  parameter int CW       = 4,
  parameter int EW       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             cfg_ok,
  input  logic [LAT_W-1:0] tccd,
  output err_e             err,
  output logic             ev_start,
  output logic             ev_intr,
  output logic             ev_bst,
  output logic             ev_done,
  output logic             rep_valid,
  output logic [EW-1:0]    rep_len,
  output logic             in_burst,
  output logic             cur_wr
);
  localparam int HALF = BL / 2;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          act_q, dir_q, open_q;
  logic [CW-1:0] cnt_q, half_q;
  logic          is_rw, want_wr, legal;

  assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign want_wr  = (cmd == CMD_WR);
  assign in_burst = act_q && (cnt_q < half_q);
  assign cur_wr   = dir_q;

  always_comb begin
    err = ERR_NONE;
    if (cmd != CMD_NOP) begin
      if (!cfg_ok) begin
        err = ERR_CFG;
      end else if (cmd == CMD_BST) begin
        if (!in_burst) err = ERR_BSTWIN;
      end else if (in_burst) begin
        if (want_wr != dir_q)                err = ERR_DIR;
        else if (cnt_q[0])                   err = ERR_ODD;
        else if (int'(cnt_q) < int'(tccd))   err = ERR_CCD;
      end else if (act_q && (want_wr != dir_q) &&
                   (int'(cnt_q) < int'(half_q) + TURN_GAP)) begin
        err = ERR_TURN;
      end
    end
  end

  assign legal    = (cmd != CMD_NOP) && (err == ERR_NONE);
  assign ev_start = legal && is_rw;
  assign ev_intr  = ev_start && in_burst;
  assign ev_bst   = legal && (cmd == CMD_BST);
  assign ev_done  = act_q && open_q && (cnt_q == half_q);

  always_comb begin
    rep_valid = ev_intr || ev_bst || ev_done;
    if (ev_intr || ev_bst) rep_len = EW'(cut_len(int'(cnt_q)));
    else if (ev_done)      rep_len = EW'(BL);
    else                   rep_len = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      open_q <= 1'b0;
      cnt_q  <= '0;
      half_q <= '0;
    end else if (ev_start) begin
      act_q  <= 1'b1;
      dir_q  <= want_wr;
      open_q <= 1'b1;
      cnt_q  <= CW'(1);
      half_q <= CW'(HALF);
    end else begin
      if (act_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (ev_bst) begin
        half_q <= cnt_q;
        open_q <= 1'b0;
      end else if (ev_done) begin
        open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/btt_stop_timer.sv
module btt_stop_timer #(
  parameter int LAT_W   = 4,
  parameter int RD_SKEW = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             is_wr,
  input  logic [LAT_W-1:0] wl,
  input  logic [LAT_W-1:0] rl,
  output logic             stop
);
  localparam int TW = LAT_W + 2;
  logic [TW-1:0] left_q;
  logic [TW-1:0] load_val;

  assign load_val = is_wr ? TW'(wl) : (TW'(rl) + TW'(RD_SKEW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      stop   <= 1'b0;
    end else begin
      stop <= (left_q == TW'(1));
      if (load)              left_q <= load_val;
      else if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/burst_trunc_tracker.sv
module burst_trunc_tracker
  import btt_pkg::*;
#(
  parameter int BL       = 8,
  parameter int LAT_W    = 4,
  parameter int RD_SKEW  = 1,
  parameter int TURN_GAP = 1,
  parameter int EW       = $clog2(BL) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [3:0]       ca,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic [LAT_W-1:0] wl,
  input  logic [LAT_W-1:0] rl,
  input  logic [LAT_W-1:0] tccd,
  output logic             viol,
  output logic [2:0]       viol_code,
  output logic             ebl_valid,
  output logic [EW-1:0]    ebl,
  output logic             burst_active,
  output logic             data_stop
);
  localparam int CW = $clog2(BL / 2 + TURN_GAP + 1) + 1;

  cmd_e          cmd;
  err_e          err;
  logic          cfg_ok;
  logic          ev_start, ev_intr, ev_bst, ev_done;
  logic          rep_valid;
  logic [EW-1:0] rep_len;
  logic          in_burst, cur_wr;

  assign cfg_ok = (wl != '0) && (rl != '0) && (tccd != '0);

  btt_cmd_decode u_dec (
    .cs_n(cs_n), .ca(ca), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd(cmd)
  );

  btt_burst_state #(
    .BL(BL), .LAT_W(LAT_W), .TURN_GAP(TURN_GAP), .CW(CW), .EW(EW)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cfg_ok(cfg_ok), .tccd(tccd),
    .err(err), .ev_start(ev_start), .ev_intr(ev_intr), .ev_bst(ev_bst),
    .ev_done(ev_done), .rep_valid(rep_valid), .rep_len(rep_len),
    .in_burst(in_burst), .cur_wr(cur_wr)
  );

  btt_stop_timer #(.LAT_W(LAT_W), .RD_SKEW(RD_SKEW)) u_stop (
    .clk(clk), .rst_n(rst_n), .load(ev_bst), .is_wr(cur_wr),
    .wl(wl), .rl(rl), .stop(data_stop)
  );

  assign burst_active = in_burst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= 3'd0;
      ebl_valid <= 1'b0;
      ebl       <= '0;
    end else begin
      viol      <= (err != ERR_NONE);
      viol_code <= err;
      ebl_valid <= rep_valid;
      ebl       <= rep_len;
    end
  end
endmodule

// File: rtl/burst_trunc_chk.sv
module burst_trunc_chk #(
  parameter int BL    = 8,
  parameter int LAT_W = 4,
  parameter int EW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic [LAT_W-1:0] wl,
  input logic [LAT_W-1:0] rl,
  input logic [LAT_W-1:0] tccd,
  input logic             viol,
  input logic [2:0]       viol_code,
  input logic             ebl_valid,
  input logic [EW-1:0]    ebl,
  input logic             burst_active,
  input logic             ev_start,
  input logic             ev_intr,
  input logic             ev_bst
);
  a_r2_intr_len_mult4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_intr |=> (ebl_valid && ebl[1:0] == 2'b00));

  a_r5_start_opens_burst: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> burst_active);

  a_r6_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bst |=> !burst_active);

  a_r7_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ebl_valid |-> (ebl != '0 && int'(ebl) <= BL));

  a_r10_zero_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (cmd_rd || cmd_wr) && (wl == '0 || rl == '0 || tccd == '0))
      |=> (viol && viol_code == 3'd6));

  a_r12_code_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code != 3'd0));

  a_r12_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> (viol_code == 3'd0));
endmodule

bind burst_trunc_tracker burst_trunc_chk #(.BL(BL), .LAT_W(LAT_W), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
  .wl(wl), .rl(rl), .tccd(tccd), .viol(viol), .viol_code(viol_code),
  .ebl_valid(ebl_valid), .ebl(ebl), .burst_active(burst_active),
  .ev_start(ev_start), .ev_intr(ev_intr), .ev_bst(ev_bst)
);

// File: tb/burst_trunc_tracker_tb.sv
module burst_trunc_tracker_tb;
  localparam int BL = 8;
  localparam int LAT_W = 4;
  localparam int EW = $clog2(BL) + 1;

  // ops: 0 nop, 1 read, 2 write, 3 stop, 4 deselected stop pattern, 5 other ca pattern
  typedef struct packed {
    logic [2:0]    op;
    logic          v;
    logic [2:0]    code;
    logic          ev;
    logic [EW-1:0] len;
    logic          act;
    logic          stp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b0},  // 0  write opens burst
    '{3'd4, 1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b0},  // 1  R1 deselected pattern
    '{3'd2, 1'b0, 3'd0, 1'b1, 4'd4, 1'b1, 1'b0},  // 2  R2 interrupt k=2
    '{3'd2, 1'b1, 3'd2, 1'b0, 4'd0, 1'b1, 1'b0},  // 3  R3 odd k=1
    '{3'd0, 1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b0},  // 4
    '{3'd0, 1'b0, 3'd0, 1'b0, 4'd0, 1'b0, 1'b0},  // 5  R3 ignored: ends on time
    '{3'd0, 1'b0, 3'd0, 1'b1, 4'd8, 1'b0, 1'b0},  // 6  R7 full length
    '{3'd1, 1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b0},  // 7  R9 read at k=5
    '{3'd5, 1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b0},  // 8  R1 other pattern
    '{3'd3, 1'b0, 3'd0, 1'b1, 4'd4, 1'b0, 1'b0},  // 9  R6 stop k=2
    '{3'd2, 1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b0},  // 10 R9 cut length used
    '{3'd0, 1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b0},  // 11
    '{3'd1, 1'b1, 3'd1, 1'b0, 4'd0, 1'b1, 1'b0},  // 12 R5 wrong direction
    '{3'd0, 1'b0, 3'd0, 1'b0, 4'd0, 1'b0, 1'b1},  // 13 R8 read stop rl+1=4
    '{3'd3, 1'b1, 3'd4, 1'b1, 4'd8, 1'b0, 1'b0},  // 14 R6 late stop, R7
    '{3'd1, 1'b0, 3'd0, 1'b0, 4'd0, 1'b1, 1'b0}   // 15
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, cmd_rd = 1'b0, cmd_wr = 1'b0;
  logic [3:0] ca = 4'd0;
  logic [LAT_W-1:0] wl = 4'd2, rl = 4'd3, tccd = 4'd2;
  logic viol, ebl_valid, burst_active, data_stop;
  logic [2:0] viol_code;
  logic [EW-1:0] ebl;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  burst_trunc_tracker #(.BL(BL), .LAT_W(LAT_W), .RD_SKEW(1), .TURN_GAP(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ca(ca), .cmd_rd(cmd_rd),
    .cmd_wr(cmd_wr), .wl(wl), .rl(rl), .tccd(tccd), .viol(viol),
    .viol_code(viol_code), .ebl_valid(ebl_valid), .ebl(ebl),
    .burst_active(burst_active), .data_stop(data_stop)
  );

  task automatic step(input logic [2:0] op);
    @(negedge clk);
    cs_n = 1'b1; cmd_rd = 1'b0; cmd_wr = 1'b0; ca = 4'd0;
    case (op)
      3'd1: begin cs_n = 1'b0; cmd_rd = 1'b1; end
      3'd2: begin cs_n = 1'b0; cmd_wr = 1'b1; end
      3'd3: begin cs_n = 1'b0; ca = 4'b0011; end
      3'd4: begin cs_n = 1'b1; ca = 4'b0011; end
      3'd5: begin cs_n = 1'b0; ca = 4'b0111; end
      default: ;
    endcase
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic v, input logic [2:0] code,
                            input logic ev, input logic [EW-1:0] len,
                            input logic act, input logic stp);
    n_chk++;
    if (viol !== v || viol_code !== code || ebl_valid !== ev || ebl !== len ||
        burst_active !== act || data_stop !== stp) begin
      n_fail++;
      $display("FAIL %s: got v=%b code=%0d ev=%b len=%0d act=%b stop=%b exp v=%b code=%0d ev=%b len=%0d act=%b stop=%b",
               req, viol, viol_code, ebl_valid, ebl, burst_active, data_stop,
               v, code, ev, len, act, stp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; cmd_rd = 1'b0; cmd_wr = 1'b0; ca = 4'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    expect_out("R11 reset state", 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op);
      expect_out($sformatf("vector %0d", i), VEC[i].v, VEC[i].code, VEC[i].ev,
                 VEC[i].len, VEC[i].act, VEC[i].stp);
    end

    // R11: reset in the middle of a burst
    do_reset(); step(3'd2);
    do_reset(); #1;
    expect_out("R11 reset mid burst", 0, 0, 0, 0, 0, 0);

    // R4: spacing below tccd
    tccd = 4'd4;
    step(3'd2); step(3'd0); step(3'd2);
    expect_out("R4 short spacing", 1, 3, 0, 0, 1, 0);
    tccd = 4'd2;

    // R10: zero latency rejects command
    do_reset(); wl = 4'd0;
    step(3'd2);
    expect_out("R10 zero wl", 1, 6, 0, 0, 0, 0);
    wl = 4'd2;

    // R6: stop with no burst after reset
    do_reset();
    step(3'd3);
    expect_out("R6 idle stop", 1, 4, 0, 0, 0, 0);

    // R8: write stop, data ends wl=2 cycles after stop edge
    do_reset();
    step(3'd2); step(3'd0); step(3'd3);
    expect_out("R6 write stop k=2", 0, 0, 1, 4, 0, 0);
    step(3'd0);
    expect_out("R8 write stop not yet", 0, 0, 0, 0, 0, 0);
    step(3'd0);
    expect_out("R8 write stop at wl", 0, 0, 0, 0, 0, 1);

    // R6: stop one cycle after command gives length 2
    do_reset();
    step(3'd1); step(3'd3);
    expect_out("R6 read stop k=1", 0, 0, 1, 2, 0, 0);

    // R9 / R7: opposite direction exactly at full burst end is too early
    do_reset();
    step(3'd2); step(3'd0); step(3'd0); step(3'd0); step(3'd1);
    expect_out("R9 turnaround early", 1, 5, 1, 8, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule